// File: doc/BRIEF.md
# Banked Address Window Translator

This block sits between a 16-bit CPU address and a wider memory space. One configurable slice of the CPU address range acts as a paged window. Any address inside that slice is moved into the wider space using a page number, a per-page shift and a base offset. Every other address is passed through unchanged. The same access is also checked against the on-chip regions: a relocatable I/O register block, a non-volatile data block, a second non-volatile block and a relocatable internal RAM. A fixed priority settles any overlap, and the winning region is reported as a one-hot select. When no on-chip region matches, the select marks the access as external.

An access is presented with `acc_vld`. Exactly one clock later, the translated address and the region select appear on the outputs together with `res_vld`. The window bounds, the shift and the virtual base are loaded through a small write port. A one-byte placement register sets where the I/O block and the RAM sit in the CPU map.

Top module: `bank_xlate`

## Requirements
- R1: After reset, the window start, window end, shift and virtual base all read as zero, so every access passes through. The placement register takes `INIT_RST` (default 8'h01). `res_vld` is 0, `res_addr` is 0 and `res_region` is 5'b10000.
- R2: An address inside the window is translated to (addr − start) + (page << shift) + vbase.
- R3: The window includes its start address and excludes its end address. If end ≤ start, the window is empty.
- R4: An address outside the window appears on `res_addr` unchanged, zero-extended to 24 bits.
- R5: For an access sampled with `acc_vld` high, the result and `res_vld` appear on the next clock edge. When `acc_vld` is low, `res_vld` drops and `res_addr`/`res_region` hold their values.
- R6: The I/O block base is placement bits 3:0 placed at address bits 15:12. It spans 64 bytes, or 1024 bytes when `IO_WIDE` is set.
- R7: The internal RAM base is placement bits 7:4 placed at address bits 15:12. It spans `RAM_BYTES` (default 1024).
- R8: Region priority runs I/O over the first non-volatile block (`EE_BASE` 16'hB000, 512 bytes), then over the second (`NV_BASE` 16'hC000, 1024 bytes), then over RAM.
- R9: `res_region` is always one-hot: bit 0 I/O, bit 1 first non-volatile block, bit 2 second non-volatile block, bit 3 RAM, bit 4 external. Bit 4 is set only when no other region matches.
- R10: A write with `cfg_we` loads the register chosen by `cfg_sel`: 0 window start (data bits 15:0), 1 window end (bits 15:0), 2 shift (bits 4:0), 3 virtual base (bits 23:0). `init_we` loads `init_wdata` into the placement register.
- R11: The translated sum wraps modulo 2^24. Page bits shifted above bit 23 are dropped.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_sel | input | 2 | Configuration register select |
| cfg_wdata | input | 24 | Configuration write data |
| init_we | input | 1 | Placement register write strobe |
| init_wdata | input | 8 | Placement register write data |
| acc_vld | input | 1 | Access valid |
| acc_addr | input | 16 | CPU address |
| acc_page | input | 8 | Current page number |
| res_vld | output | 1 | Result valid, one cycle after the access |
| res_addr | output | 24 | Translated address |
| res_region | output | 5 | One-hot region select |

## Verification
A wrong window bound or a stale shift or base value shows up on `res_addr` on the very next result. Such an error is most visible at the two window edges and when high page bits are shifted beyond bit 23. A wrong placement register moves the I/O or RAM hit to a different 4 KB slot. A broken priority chain selects a lower region where two regions overlap. Either fault shows in `res_region` one cycle after the access. The stimulus therefore probes both sides of every region edge and each overlapping pair.

// File: rtl/bank_xlate_pkg.sv
package bank_xlate_pkg;

   // Region select bit positions; the external bit is the last one.
   localparam int REG_IO  = 0;
   localparam int REG_EE  = 1;
   localparam int REG_NV  = 2;
   localparam int REG_RAM = 3;
   localparam int REG_EXT = 4;
   localparam int REG_N   = 5;

   typedef enum logic [1:0] {
      CFG_WIN_LO = 2'd0,
      CFG_WIN_HI = 2'd1,
      CFG_SHIFT  = 2'd2,
      CFG_VBASE  = 2'd3
   } cfg_sel_e;

   // True when a lies in [base, base + bytes).
   function automatic logic span_hit(input logic [15:0] a,
                                     input logic [15:0] base,
                                     input int unsigned bytes);
      logic [31:0] a_w;
      logic [31:0] b_w;
      a_w = 32'(a);
      b_w = 32'(base);
      return (a_w >= b_w) && (a_w < (b_w + bytes));
   endfunction

endpackage

// File: rtl/bank_cfg_regs.sv
module bank_cfg_regs
   import bank_xlate_pkg::*;
#(
   parameter int         ADDR_W   = 16,
   parameter int         PHYS_W   = 24,
   parameter int         SHIFT_W  = 5,
   parameter logic [7:0] INIT_RST = 8'h01
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               cfg_we,
   input  logic [1:0]         cfg_sel,
   input  logic [PHYS_W-1:0]  cfg_wdata,
   input  logic               init_we,
   input  logic [7:0]         init_wdata,
   output logic [ADDR_W-1:0]  win_lo,
   output logic [ADDR_W-1:0]  win_hi,
   output logic [SHIFT_W-1:0] shift,
   output logic [PHYS_W-1:0]  vbase,
   output logic [7:0]         init_q
);

   cfg_sel_e sel;
   assign sel = cfg_sel_e'(cfg_sel);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         win_lo <= '0;
         win_hi <= '0;
         shift  <= '0;
         vbase  <= '0;
      end else if (cfg_we) begin
         case (sel)
            CFG_WIN_LO: win_lo <= cfg_wdata[ADDR_W-1:0];
            CFG_WIN_HI: win_hi <= cfg_wdata[ADDR_W-1:0];
            CFG_SHIFT:  shift  <= cfg_wdata[SHIFT_W-1:0];
            default:    vbase  <= cfg_wdata;
         endcase
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)       init_q <= INIT_RST;
      else if (init_we) init_q <= init_wdata;
   end

   // R10: a shift write lands in the shift register on the next edge
   a_r10_shift_load: assert property (@(posedge clk) disable iff (!rst_n)
      (cfg_we && cfg_sel == 2'd2) |=> shift == $past(cfg_wdata[SHIFT_W-1:0]));

   // R10: a write to another register leaves the window start untouched
   a_r10_lo_keep: assert property (@(posedge clk) disable iff (!rst_n)
      (cfg_we && cfg_sel != 2'd0) |=> $stable(win_lo));

endmodule

// File: rtl/bank_window_xlate.sv
module bank_window_xlate #(
   parameter int ADDR_W  = 16,
   parameter int PAGE_W  = 8,
   parameter int PHYS_W  = 24,
   parameter int SHIFT_W = 5
) (
   input  logic [ADDR_W-1:0]  addr,
   input  logic [PAGE_W-1:0]  page,
   input  logic [ADDR_W-1:0]  win_lo,
   input  logic [ADDR_W-1:0]  win_hi,
   input  logic [SHIFT_W-1:0] shift,
   input  logic [PHYS_W-1:0]  vbase,
   output logic               hit,
   output logic [PHYS_W-1:0]  phys
);

   logic [ADDR_W-1:0] off;
   logic [PHYS_W-1:0] off_ext;
   logic [PHYS_W-1:0] page_sh;
   logic [PHYS_W-1:0] xlat;

   always_comb begin
      hit     = (addr >= win_lo) && (addr < win_hi);
      off     = addr - win_lo;
      off_ext = PHYS_W'(off);
      page_sh = PHYS_W'(page) << shift;
      xlat    = off_ext + page_sh + vbase;
      phys    = hit ? xlat : PHYS_W'(addr);
   end

endmodule

// File: rtl/bank_region_decode.sv
module bank_region_decode
   import bank_xlate_pkg::*;
#(
   parameter int          ADDR_W    = 16,
   parameter bit          IO_WIDE   = 1'b0,
   parameter int unsigned RAM_BYTES = 1024,
   parameter logic [15:0] EE_BASE   = 16'hB000,
   parameter int unsigned EE_BYTES  = 512,
   parameter logic [15:0] NV_BASE   = 16'hC000,
   parameter int unsigned NV_BYTES  = 1024
) (
   input  logic [ADDR_W-1:0] addr,
   input  logic [7:0]        init_q,
   output logic [REG_N-2:0]  raw,
   output logic [REG_N-1:0]  sel
);

   localparam int NIB_LO = ADDR_W - 4;

   logic io_hit;
   logic ram_hit;
   logic ee_hit;
   logic nv_hit;

   // I/O span variant: the two sizes differ only in how many offset
   // bits must be zero inside the selected 4 KB slot.
   generate
      if (IO_WIDE) begin : g_io_wide
         localparam int IO_LG = 10;
         assign io_hit = (addr[ADDR_W-1:NIB_LO] == init_q[3:0]) &&
                         (addr[NIB_LO-1:IO_LG] == '0);
      end else begin : g_io_narrow
         localparam int IO_LG = 6;
         assign io_hit = (addr[ADDR_W-1:NIB_LO] == init_q[3:0]) &&
                         (addr[NIB_LO-1:IO_LG] == '0);
      end
   endgenerate

   assign ram_hit = (addr[ADDR_W-1:NIB_LO] == init_q[7:4]) &&
                    (32'(addr[NIB_LO-1:0]) < RAM_BYTES);
   assign ee_hit  = span_hit(addr, EE_BASE, EE_BYTES);
   assign nv_hit  = span_hit(addr, NV_BASE, NV_BYTES);

   always_comb begin
      raw          = '0;
      raw[REG_IO]  = io_hit;
      raw[REG_EE]  = ee_hit;
      raw[REG_NV]  = nv_hit;
      raw[REG_RAM] = ram_hit;
   end

   // Fixed priority: lower index wins.
   generate
      for (genvar i = 0; i < REG_N - 1; i++) begin : g_prio
         if (i == 0) begin : g_first
            assign sel[i] = raw[i];
         end else begin : g_rest
            assign sel[i] = raw[i] & ~(|raw[i-1:0]);
         end
      end
   endgenerate

   assign sel[REG_EXT] = ~(|raw);

endmodule

// File: rtl/bank_xlate.sv
module bank_xlate
   import bank_xlate_pkg::*;
#(
   parameter int          ADDR_W    = 16,
   parameter int          PAGE_W    = 8,
   parameter int          PHYS_W    = 24,
   parameter int          SHIFT_W   = 5,
   parameter bit          IO_WIDE   = 1'b0,
   parameter int unsigned RAM_BYTES = 1024,
   parameter logic [15:0] EE_BASE   = 16'hB000,
   parameter int unsigned EE_BYTES  = 512,
   parameter logic [15:0] NV_BASE   = 16'hC000,
   parameter int unsigned NV_BYTES  = 1024,
   parameter logic [7:0]  INIT_RST  = 8'h01
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              cfg_we,
   input  logic [1:0]        cfg_sel,
   input  logic [23:0]       cfg_wdata,
   input  logic              init_we,
   input  logic [7:0]        init_wdata,
   input  logic              acc_vld,
   input  logic [15:0]       acc_addr,
   input  logic [7:0]        acc_page,
   output logic              res_vld,
   output logic [23:0]       res_addr,
   output logic [4:0]        res_region
);

   localparam logic [REG_N-1:0] REGION_RST = REG_N'(1) << REG_EXT;

   generate
      if (ADDR_W != 16) begin : g_chk_addr
         $error("bank_xlate: ADDR_W must be 16");
      end
      if (PHYS_W != 24 || PAGE_W != 8) begin : g_chk_port
         $error("bank_xlate: port widths fixed at PHYS_W=24, PAGE_W=8");
      end
      if (PHYS_W < ADDR_W) begin : g_chk_phys
         $error("bank_xlate: PHYS_W must cover ADDR_W");
      end
      if (SHIFT_W < 1 || SHIFT_W > 6) begin : g_chk_shift
         $error("bank_xlate: SHIFT_W out of range");
      end
      if (RAM_BYTES > 4096 || RAM_BYTES == 0) begin : g_chk_ram
         $error("bank_xlate: RAM must fit inside one 4 KB slot");
      end
   endgenerate

   logic [ADDR_W-1:0]  win_lo;
   logic [ADDR_W-1:0]  win_hi;
   logic [SHIFT_W-1:0] shift;
   logic [PHYS_W-1:0]  vbase;
   logic [7:0]         init_q;
   logic               win_hit;
   logic [PHYS_W-1:0]  phys;
   logic [REG_N-2:0]   raw;
   logic [REG_N-1:0]   sel;

   bank_cfg_regs #(
      .ADDR_W(ADDR_W), .PHYS_W(PHYS_W), .SHIFT_W(SHIFT_W), .INIT_RST(INIT_RST)
   ) u_cfg (
      .clk(clk), .rst_n(rst_n),
      .cfg_we(cfg_we), .cfg_sel(cfg_sel), .cfg_wdata(cfg_wdata),
      .init_we(init_we), .init_wdata(init_wdata),
      .win_lo(win_lo), .win_hi(win_hi), .shift(shift), .vbase(vbase),
      .init_q(init_q)
   );

   bank_window_xlate #(
      .ADDR_W(ADDR_W), .PAGE_W(PAGE_W), .PHYS_W(PHYS_W), .SHIFT_W(SHIFT_W)
   ) u_win (
      .addr(acc_addr), .page(acc_page),
      .win_lo(win_lo), .win_hi(win_hi), .shift(shift), .vbase(vbase),
      .hit(win_hit), .phys(phys)
   );

   bank_region_decode #(
      .ADDR_W(ADDR_W), .IO_WIDE(IO_WIDE), .RAM_BYTES(RAM_BYTES),
      .EE_BASE(EE_BASE), .EE_BYTES(EE_BYTES),
      .NV_BASE(NV_BASE), .NV_BYTES(NV_BYTES)
   ) u_dec (
      .addr(acc_addr), .init_q(init_q), .raw(raw), .sel(sel)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         res_vld    <= 1'b0;
         res_addr   <= '0;
         res_region <= REGION_RST;
      end else begin
         res_vld <= acc_vld;
         if (acc_vld) begin
            res_addr   <= phys;
            res_region <= sel;
         end
      end
   end

   // R5: every access yields a result on the next edge
   a_r5_latency: assert property (@(posedge clk) disable iff (!rst_n)
      acc_vld |=> res_vld);

   // R5: idle cycles drop valid and keep the outputs
   a_r5_hold: assert property (@(posedge clk) disable iff (!rst_n)
      !acc_vld |=> (!res_vld && $stable(res_addr) && $stable(res_region)));

   // R9: exactly one region bit at all times
   a_r9_onehot: assert property (@(posedge clk) disable iff (!rst_n)
      $countones(res_region) == 1);

   // R9: external only when the decoder saw no on-chip hit
   a_r9_ext: assert property (@(posedge clk) disable iff (!rst_n)
      (acc_vld && raw == '0) |=> res_region[REG_EXT]);

   // R8: an I/O hit beats every other region
   a_r8_io_wins: assert property (@(posedge clk) disable iff (!rst_n)
      (acc_vld && raw[REG_IO]) |=> res_region[REG_IO]);

   // R4: outside the window the address is passed through
   a_r4_passthru: assert property (@(posedge clk) disable iff (!rst_n)
      (acc_vld && !win_hit) |=> res_addr == PHYS_W'($past(acc_addr)));

   // R3: an empty window never translates
   a_r3_empty: assert property (@(posedge clk) disable iff (!rst_n)
      (win_hi <= win_lo) |-> !win_hit);

endmodule

// File: tb/bank_xlate_tb.sv
module bank_xlate_tb_top;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        cfg_we = 1'b0;
   logic [1:0]  cfg_sel = '0;
   logic [23:0] cfg_wdata = '0;
   logic        init_we = 1'b0;
   logic [7:0]  init_wdata = '0;
   logic        acc_vld = 1'b0;
   logic [15:0] acc_addr = '0;
   logic [7:0]  acc_page = '0;
   logic        res_vld;
   logic [23:0] res_addr;
   logic [4:0]  res_region;

   always #5 clk = ~clk;

   bank_xlate dut_i (
      .clk(clk), .rst_n(rst_n),
      .cfg_we(cfg_we), .cfg_sel(cfg_sel), .cfg_wdata(cfg_wdata),
      .init_we(init_we), .init_wdata(init_wdata),
      .acc_vld(acc_vld), .acc_addr(acc_addr), .acc_page(acc_page),
      .res_vld(res_vld), .res_addr(res_addr), .res_region(res_region)
   );

   int n_chk = 0;
   int n_bad = 0;
   bit done  = 1'b0;

   // Bench model of configuration, kept from the requirements.
   int unsigned m_lo = 0, m_hi = 0, m_sh = 0, m_vb = 0;
   logic [7:0]  m_init = 8'h01;

   logic [23:0] q_addr[$];
   logic [4:0]  q_reg[$];
   string       q_tag[$];

   task automatic check(input string tag, input bit ok,
                        input logic [31:0] act, input logic [31:0] exp);
      n_chk++;
      if (!ok) begin
         n_bad++;
         $display("FAIL %s actual=%h expected=%h", tag, act, exp);
      end
   endtask

   function automatic logic [23:0] exp_addr(input int unsigned a, input int unsigned p);
      if (a >= m_lo && a < m_hi)
         return 24'(((a - m_lo) + ((p << m_sh) & 32'hFF_FFFF) + m_vb) & 32'hFF_FFFF);
      return 24'(a);
   endfunction

   function automatic logic [4:0] exp_region(input logic [15:0] a);
      bit io, ee, nv, ram;
      io  = (a[15:12] == m_init[3:0]) && (a[11:0] < 12'd64);
      ram = (a[15:12] == m_init[7:4]) && (a[11:0] < 12'd1024);
      ee  = (a >= 16'hB000) && (a < 16'hB200);
      nv  = (a >= 16'hC000) && (a < 16'hC400);
      if (io)  return 5'b00001;
      if (ee)  return 5'b00010;
      if (nv)  return 5'b00100;
      if (ram) return 5'b01000;
      return 5'b10000;
   endfunction

   // Driver: caller sits just after a negedge.
   task automatic access(input string tag, input logic [15:0] a, input logic [7:0] p);
      acc_vld  = 1'b1;
      acc_addr = a;
      acc_page = p;
      q_addr.push_back(exp_addr(32'(a), 32'(p)));
      q_reg.push_back(exp_region(a));
      q_tag.push_back(tag);
      @(negedge clk);
   endtask

   task automatic idle();
      acc_vld = 1'b0;
      @(negedge clk);
   endtask

   task automatic cfg_write(input logic [1:0] s, input logic [23:0] d);
      acc_vld   = 1'b0;
      cfg_we    = 1'b1;
      cfg_sel   = s;
      cfg_wdata = d;
      case (s)
         2'd0: m_lo = 32'(d[15:0]);
         2'd1: m_hi = 32'(d[15:0]);
         2'd2: m_sh = 32'(d[4:0]);
         default: m_vb = 32'(d);
      endcase
      @(negedge clk);
      cfg_we = 1'b0;
   endtask

   task automatic init_write(input logic [7:0] d);
      acc_vld    = 1'b0;
      init_we    = 1'b1;
      init_wdata = d;
      m_init     = d;
      @(negedge clk);
      init_we = 1'b0;
   endtask

   // Monitor: compare each result against the oldest expected item.
   always @(negedge clk) begin
      if (rst_n && res_vld) begin
         if (q_addr.size() == 0) begin
            check("R5 unexpected result", 1'b0, 32'(res_addr), 32'hFFFF_FFFF);
         end else begin
            logic [23:0] ea;
            logic [4:0]  er;
            string       t;
            ea = q_addr.pop_front();
            er = q_reg.pop_front();
            t  = q_tag.pop_front();
            check({t, " addr"},   res_addr == ea,   32'(res_addr),   32'(ea));
            check({t, " region"}, res_region == er, 32'(res_region), 32'(er));
         end
      end
   end

   initial begin
      repeat (20000) @(posedge clk);
      if (!done) begin
         n_chk++;
         n_bad++;
         $display("FAIL watchdog actual=timeout expected=finish");
         $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
         $finish;
      end
   end

   initial begin
      logic [23:0] held;
      repeat (3) @(negedge clk);
      // R1: reset values at the outputs
      check("R1 res_vld",    res_vld == 1'b0,        32'(res_vld),    32'h0);
      check("R1 res_addr",   res_addr == 24'h0,      32'(res_addr),   32'h0);
      check("R1 res_region", res_region == 5'b10000, 32'(res_region), 32'h10);
      rst_n = 1'b1;
      @(negedge clk);

      // R1, R4: cleared window means pass-through; default placement
      access("R1 pass after reset", 16'h4000, 8'h05);
      access("R7 default RAM",      16'h0100, 8'h00);
      access("R6 default IO",       16'h1020, 8'h00);
      access("R6 IO edge",          16'h1040, 8'h00);
      idle();

      // R10, R2, R3: window 8000..BFFF, shift 14, base 100000
      cfg_write(2'd0, 24'h00_8000);
      cfg_write(2'd1, 24'h00_C000);
      cfg_write(2'd2, 24'h00_000E);
      cfg_write(2'd3, 24'h10_0000);
      access("R3 start inclusive", 16'h8000, 8'h03);
      access("R3 last inside",     16'hBFFF, 8'h00);
      access("R3 end exclusive",   16'hC000, 8'h07);
      access("R4 below window",    16'h7FFF, 8'h07);
      access("R2 mid window",      16'hA123, 8'h02);
      access("R2 window over NV1", 16'hB010, 8'h01);
      idle();

      // R5: outputs hold while idle even as inputs change
      held = res_addr;
      acc_addr = 16'h1234;
      acc_page = 8'h99;
      repeat (3) @(negedge clk);
      check("R5 hold addr", res_addr == held, 32'(res_addr), 32'(held));
      check("R5 hold vld",  res_vld == 1'b0,  32'(res_vld),  32'h0);

      // R11: wrap of the sum and of shifted page bits
      cfg_write(2'd2, 24'h00_0010);
      cfg_write(2'd3, 24'hFF_0000);
      access("R11 sum wraps", 16'h8010, 8'hFF);
      idle();
      cfg_write(2'd2, 24'h00_0014);
      cfg_write(2'd3, 24'h00_0000);
      access("R11 page bits dropped", 16'h8000, 8'h12);
      idle();

      // R3: empty window
      cfg_write(2'd0, 24'h00_9000);
      cfg_write(2'd1, 24'h00_9000);
      access("R3 empty window", 16'h9000, 8'h44);
      idle();

      // R6, R7: relocation through the placement register
      init_write(8'h22);
      access("R6 IO moved",       16'h2010, 8'h00);
      access("R6 IO span end",    16'h2040, 8'h00);
      access("R6 old IO gone",    16'h1000, 8'h00);
      access("R7 RAM moved",      16'h2100, 8'h00);
      access("R7 RAM last",       16'h23FF, 8'h00);
      access("R7 RAM past end",   16'h2400, 8'h00);
      access("R7 old RAM gone",   16'h0100, 8'h00);
      idle();

      // R8, R9: overlap priority
      init_write(8'hCB);
      access("R8 IO over NV1",   16'hB010, 8'h00);
      access("R8 NV1 alone",     16'hB040, 8'h00);
      access("R8 NV2 over RAM",  16'hC100, 8'h00);
      access("R9 external",      16'hC400, 8'h00);
      idle();
      init_write(8'hBB);
      access("R8 IO over all",   16'hB000, 8'h00);
      access("R8 NV1 over RAM",  16'hB100, 8'h00);
      access("R8 RAM after NV1", 16'hB300, 8'h00);
      idle();
      idle();

      check("R5 all results seen", q_addr.size() == 0,
            32'(q_addr.size()), 32'h0);
      done = 1'b1;
      $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
      $finish;
   end

endmodule